// File: doc/BRIEF.md
# Inbound Message Queue Post Port

This block takes message frame addresses that a host writes to a fixed port offset in the first memory window. It appends each one to a circular list held in local memory. For every accepted post it issues one memory write request. The request address is formed from a programmable base, one ring span and the current head offset. The head offset advances only when the memory acknowledges the write. The local processor reads entries out of memory on its own and then moves the tail offset forward through a small register interface.

While the list holds entries, the block drives a local interrupt. A mask bit can gate that interrupt. The status bit behind it clears by itself once the tail catches up with the head. While a post is in flight to memory, every other slave access reaches the block with a retry indication, so nothing can observe the list half-updated. A post that arrives when the ring is full is discarded and sets a sticky overflow flag.

Top module: `ipq_post_port`

## Requirements
- R1: A host access with window-0 hit, write, offset 0x40 while no post is in flight and the ring is not full starts a memory write whose data is the written value. Any other offset, a read, or a window-0 miss starts no write and leaves the head unchanged.
- R2: The memory write address equals base + span + head. The span is 16 KiB << code. Codes above 4 act as 4.
- R3: mem_req stays high with stable mem_addr and mem_data until the cycle mem_ack is seen. The head offset advances by 4 only in that cycle.
- R4: The head offset wraps to 0 after the last slot of the span.
- R5: From the cycle after a post is accepted through its ack cycle, every host access sees hst_retry high in the same cycle and has no effect. At other times hst_retry is low.
- R6: Writing local register 3 sets the tail offset to the written value with bits 1:0 cleared, reduced modulo the span. Reading register 3 returns it.
- R7: Bit 0 of local register 4 reads 1 exactly when head differs from tail. local_irq equals that bit gated off by the mask at bit 1 of register 4, which is read/write.
- R8: When head+4 equals tail modulo the span, a port write is dropped: no memory write occurs and the head is unchanged. Bit 2 of register 4 becomes 1, and writing 1 to that bit clears it.
- R9: After reset, all local registers read 0 and mem_req, hst_retry and local_irq are low.
- R10: Register 0 holds the 32-bit base, register 1 holds the size code in bits 2:0, and register 2 reads the head offset. All are readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_acc_valid | input | 1 | A host slave access is presented this cycle |
| hst_acc_write | input | 1 | The access is a write |
| hst_acc_win0 | input | 1 | The access hits the first memory window |
| hst_acc_off | input | 8 | Byte offset of the access within the window |
| hst_acc_wdata | input | 32 | Write data of the access |
| hst_retry | output | 1 | The access presented this cycle must be retried |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory write byte address |
| mem_data | output | 32 | Memory write data (the posted frame address) |
| mem_ack | input | 1 | Single-cycle acknowledge of the memory write |
| loc_we | input | 1 | Local register write strobe |
| loc_sel | input | 3 | Local register index |
| loc_wdata | input | 32 | Local register write data |
| loc_rdata | output | 32 | Local register read data for loc_sel |
| local_irq | output | 1 | Interrupt to the local processor |

## Verification
A head offset that moves at the wrong time or by the wrong step shows up at the ports on the next post. That post's mem_addr lands on the wrong slot, and register 2 disagrees with the expected offset right after the ack cycle. A stale in-flight flag shows up immediately. Either hst_retry is seen in a cycle when it should be low, or a retried port write produces a second request on the following edge. A wrong full or empty comparison is caught within one access: a post is dropped or written against the expectation, or local_irq and status bit 0 disagree with head versus tail.

// File: rtl/ipq_pkg.sv
package ipq_pkg;

  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    RG_BASE = 3'd0,
    RG_SIZE = 3'd1,
    RG_HEAD = 3'd2,
    RG_TAIL = 3'd3,
    RG_CTRL = 3'd4
  } reg_sel_e;

  localparam int unsigned CTRL_NE_BIT   = 0;
  localparam int unsigned CTRL_MASK_BIT = 1;
  localparam int unsigned CTRL_OVF_BIT  = 2;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_WRITE = 1'b1
  } post_st_e;

endpackage

// File: rtl/ipq_ring_regs.sv
module ipq_ring_regs
  import ipq_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned MIN_LOG2  = 14,
  parameter int unsigned NUM_SIZES = 5,
  parameter int unsigned PTR_W     = MIN_LOG2 + NUM_SIZES - 1,
  parameter int unsigned CODE_W    = $clog2(NUM_SIZES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_we,
  input  logic [SEL_W-1:0]  loc_sel,
  input  logic [DATA_W-1:0] loc_wdata,
  input  logic              head_adv,
  input  logic              set_ovf,
  output logic [ADDR_W-1:0] base_q,
  output logic [PTR_W:0]    span,
  output logic [PTR_W-1:0]  head_q,
  output logic [PTR_W-1:0]  tail_q,
  output logic              mask_q,
  output logic              ovf_q,
  output logic              ring_full,
  output logic              ring_nonempty,
  output logic [DATA_W-1:0] loc_rdata
);

  localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(NUM_SIZES - 1);

  // Byte span of the ring for a size code; codes past the last size saturate.
  function automatic logic [PTR_W:0] span_of(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] c;
    c = (code > CODE_MAX) ? CODE_MAX : code;
    return {{PTR_W{1'b0}}, 1'b1} << (MIN_LOG2 + int'(c));
  endfunction

  // Next slot offset, one 4-byte entry further, folded into the ring.
  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] ptr,
                                                input logic [PTR_W-1:0] msk);
    return (ptr + PTR_W'(4)) & msk;
  endfunction

  logic [CODE_W-1:0] code_q;
  logic [PTR_W-1:0]  ptr_mask;
  logic [PTR_W:0]    span_m1;
  logic              wr_base, wr_size, wr_tail, wr_ctrl;

  assign span     = span_of(code_q);
  assign span_m1  = span - {{PTR_W{1'b0}}, 1'b1};
  assign ptr_mask = span_m1[PTR_W-1:0];

  assign wr_base = loc_we && (loc_sel == RG_BASE);
  assign wr_size = loc_we && (loc_sel == RG_SIZE);
  assign wr_tail = loc_we && (loc_sel == RG_TAIL);
  assign wr_ctrl = loc_we && (loc_sel == RG_CTRL);

  assign ring_nonempty = (head_q != tail_q);
  assign ring_full     = (step_ptr(head_q, ptr_mask) == tail_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      code_q <= '0;
      head_q <= '0;
      tail_q <= '0;
      mask_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_base) base_q <= loc_wdata[ADDR_W-1:0];
      if (wr_size) code_q <= loc_wdata[CODE_W-1:0];
      if (head_adv) head_q <= step_ptr(head_q, ptr_mask);
      if (wr_tail) tail_q <= loc_wdata[PTR_W-1:0] & ptr_mask & ~PTR_W'(3);
      if (wr_ctrl) mask_q <= loc_wdata[CTRL_MASK_BIT];
      if (set_ovf) ovf_q <= 1'b1;
      else if (wr_ctrl && loc_wdata[CTRL_OVF_BIT]) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    loc_rdata = '0;
    case (loc_sel)
      RG_BASE: loc_rdata = DATA_W'(base_q);
      RG_SIZE: loc_rdata = DATA_W'(code_q);
      RG_HEAD: loc_rdata = DATA_W'(head_q);
      RG_TAIL: loc_rdata = DATA_W'(tail_q);
      RG_CTRL: begin
        loc_rdata[CTRL_NE_BIT]   = ring_nonempty;
        loc_rdata[CTRL_MASK_BIT] = mask_q;
        loc_rdata[CTRL_OVF_BIT]  = ovf_q;
      end
      default: loc_rdata = '0;
    endcase
  end

  AST_HEAD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !head_adv |=> $stable(head_q)); // R3

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    set_ovf |=> ovf_q); // R8

endmodule

// File: rtl/ipq_addr_gen.sv
module ipq_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PTR_W  = 18
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [PTR_W:0]    span,
  input  logic [PTR_W-1:0]  head,
  output logic [ADDR_W-1:0] slot_addr
);

  // The post list sits one ring span above the queue base.
  function automatic logic [ADDR_W-1:0] post_slot(input logic [ADDR_W-1:0] b,
                                                 input logic [PTR_W:0]    s,
                                                 input logic [PTR_W-1:0]  h);
    return b + ADDR_W'(s) + ADDR_W'(h);
  endfunction

  assign slot_addr = post_slot(base, span, head);

endmodule

// File: rtl/ipq_post_fsm.sv
module ipq_post_fsm
  import ipq_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFF_W    = 8,
  parameter logic [OFF_W-1:0] PORT_OFF = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_win0,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              ring_full,
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              retry,
  output logic              post_accept,
  output logic              post_drop,
  output logic              post_done
);

  post_st_e st_q;
  logic     busy;
  logic     port_hit;

  assign busy        = (st_q == ST_WRITE);
  assign port_hit    = acc_valid && acc_write && acc_win0 && (acc_off == PORT_OFF);
  assign post_accept = port_hit && !busy && !ring_full;
  assign post_drop   = port_hit && !busy && ring_full;
  assign post_done   = busy && mem_ack;
  assign retry       = acc_valid && busy;
  assign mem_req     = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (post_accept) begin
          st_q     <= ST_WRITE;
          mem_addr <= slot_addr;
          mem_data <= acc_wdata;
        end
        ST_WRITE: if (mem_ack) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_data)); // R3

  AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    post_drop |=> !mem_req); // R8

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    post_accept |=> mem_req && (mem_data == $past(acc_wdata))); // R1

endmodule

// File: rtl/ipq_post_port.sv
module ipq_post_port
  import ipq_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned OFF_W     = 8,
  parameter logic [OFF_W-1:0] PORT_OFF = 8'h40,
  parameter int unsigned MIN_LOG2  = 14,
  parameter int unsigned NUM_SIZES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_acc_valid,
  input  logic              hst_acc_write,
  input  logic              hst_acc_win0,
  input  logic [OFF_W-1:0]  hst_acc_off,
  input  logic [DATA_W-1:0] hst_acc_wdata,
  output logic              hst_retry,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  input  logic              mem_ack,
  input  logic              loc_we,
  input  logic [SEL_W-1:0]  loc_sel,
  input  logic [DATA_W-1:0] loc_wdata,
  output logic [DATA_W-1:0] loc_rdata,
  output logic              local_irq
);

  localparam int unsigned PTR_W  = MIN_LOG2 + NUM_SIZES - 1;
  localparam int unsigned CODE_W = $clog2(NUM_SIZES);

  logic [ADDR_W-1:0] base_q;
  logic [PTR_W:0]    span;
  logic [PTR_W-1:0]  head_q, tail_q;
  logic              mask_q, ovf_q;
  logic              ring_full, ring_nonempty;
  logic [ADDR_W-1:0] slot_addr;
  logic              post_accept, post_drop, post_done;

  ipq_ring_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MIN_LOG2(MIN_LOG2),
    .NUM_SIZES(NUM_SIZES), .PTR_W(PTR_W), .CODE_W(CODE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .loc_we(loc_we), .loc_sel(loc_sel), .loc_wdata(loc_wdata),
    .head_adv(post_done), .set_ovf(post_drop),
    .base_q(base_q), .span(span), .head_q(head_q), .tail_q(tail_q),
    .mask_q(mask_q), .ovf_q(ovf_q),
    .ring_full(ring_full), .ring_nonempty(ring_nonempty),
    .loc_rdata(loc_rdata)
  );

  ipq_addr_gen #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_addr (
    .base(base_q), .span(span), .head(head_q), .slot_addr(slot_addr)
  );

  ipq_post_fsm #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PORT_OFF(PORT_OFF)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(hst_acc_valid), .acc_write(hst_acc_write),
    .acc_win0(hst_acc_win0), .acc_off(hst_acc_off), .acc_wdata(hst_acc_wdata),
    .ring_full(ring_full), .slot_addr(slot_addr), .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
    .retry(hst_retry),
    .post_accept(post_accept), .post_drop(post_drop), .post_done(post_done)
  );

  assign local_irq = ring_nonempty && !mask_q;

  AST_RETRY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    hst_retry |-> !post_accept && !post_drop); // R5

  AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (head_q == tail_q) |-> !local_irq); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ring_full |-> !post_accept); // R8

  AST_SLOT_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((mem_addr - base_q - ADDR_W'(span)) < ADDR_W'(span))); // R2

endmodule

// File: tb/sim_ipq_post_port.sv
module sim_ipq_post_port;
  import ipq_pkg::*;

  localparam int CLK_HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_acc_valid = 0, hst_acc_write = 0, hst_acc_win0 = 0;
  logic [7:0]  hst_acc_off = '0;
  logic [31:0] hst_acc_wdata = '0;
  logic        hst_retry, mem_req, mem_ack = 0, loc_we = 0, local_irq;
  logic [31:0] mem_addr, mem_data, loc_wdata = '0, loc_rdata;
  logic [2:0]  loc_sel = '0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] base_m = 32'h8000_0000, span_m = 32'h4000, head_m = 0;

  always #CLK_HALF clk = ~clk;

  ipq_post_port u0 (
    .clk(clk), .rst_n(rst_n),
    .hst_acc_valid(hst_acc_valid), .hst_acc_write(hst_acc_write),
    .hst_acc_win0(hst_acc_win0), .hst_acc_off(hst_acc_off),
    .hst_acc_wdata(hst_acc_wdata), .hst_retry(hst_retry),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ack(mem_ack), .loc_we(loc_we), .loc_sel(loc_sel),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .local_irq(local_irq)
  );

  // {win0, write, off[7:0], data[31:0], expect_post}
  localparam logic [42:0] VEC [6] = '{
    {1'b1, 1'b1, 8'h40, 32'h0001_0000, 1'b1},
    {1'b0, 1'b1, 8'h40, 32'hDEAD_0001, 1'b0},
    {1'b1, 1'b0, 8'h40, 32'hDEAD_0002, 1'b0},
    {1'b1, 1'b1, 8'h44, 32'hDEAD_0003, 1'b0},
    {1'b1, 1'b1, 8'h3C, 32'hDEAD_0004, 1'b0},
    {1'b1, 1'b1, 8'h40, 32'h0002_0040, 1'b1}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [2:0] sel, output logic [31:0] val);
    @(negedge clk);
    loc_we = 0; loc_sel = sel;
    #1 val = loc_rdata;
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [31:0] val);
    @(negedge clk);
    loc_we = 1; loc_sel = sel; loc_wdata = val;
    @(negedge clk);
    loc_we = 0;
  endtask

  // One-cycle host access; returns at the negedge after the capturing edge.
  task automatic host_acc(input logic win, input logic wr, input logic [7:0] off,
                          input logic [31:0] d);
    @(negedge clk);
    hst_acc_valid = 1; hst_acc_win0 = win; hst_acc_write = wr;
    hst_acc_off = off; hst_acc_wdata = d;
    @(negedge clk);
    hst_acc_valid = 0;
  endtask

  // Called at a negedge with a request pending: holds, then acks once.
  task automatic finish_post(input logic [31:0] d, input int hold);
    logic [31:0] a0, v;
    #1;
    chk({31'b0, mem_req}, 32'd1, "R1 post starts write");
    chk(mem_addr, base_m + span_m + head_m, "R2 slot address");
    chk(mem_data, d, "R1 write data");
    a0 = mem_addr;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk); #1;
      chk({31'b0, mem_req}, 32'd1, "R3 req held");
      chk(mem_addr, a0, "R3 addr stable");
    end
    mem_ack = 1;
    @(negedge clk);
    mem_ack = 0;
    #1 chk({31'b0, mem_req}, 32'd0, "R3 req drops after ack");
    head_m = (head_m + 4) % span_m;
    rd_reg(RG_HEAD, v);
    chk(v, head_m, "R3 head advanced by 4");
  endtask

  task automatic fast_post(input logic [31:0] d);
    host_acc(1, 1, 8'h40, d);
    mem_ack = 1;
    @(negedge clk);
    mem_ack = 0;
    head_m = (head_m + 4) % span_m;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R9 reset state
    #1;
    chk({29'b0, mem_req, hst_retry, local_irq}, 32'd0, "R9 outputs after reset");
    for (int s = 0; s < 5; s++) begin
      rd_reg(3'(s), v);
      chk(v, 32'd0, "R9 register after reset");
    end

    // R10 programming and readback
    wr_reg(RG_BASE, base_m);
    wr_reg(RG_SIZE, 32'd0);
    rd_reg(RG_BASE, v); chk(v, base_m, "R10 base readback");
    rd_reg(RG_SIZE, v); chk(v, 32'd0, "R10 size readback");

    // R1 decode table
    for (int i = 0; i < 6; i++) begin
      host_acc(VEC[i][42], VEC[i][41], VEC[i][40:33], VEC[i][32:1]);
      if (VEC[i][0]) finish_post(VEC[i][32:1], i % 3);
      else begin
        #1 chk({31'b0, mem_req}, 32'd0, "R1 non-port access ignored");
        rd_reg(RG_HEAD, v); chk(v, head_m, "R1 head unchanged");
      end
    end

    // R7 status and interrupt
    #1 chk({31'b0, local_irq}, 32'd1, "R7 irq when nonempty");
    rd_reg(RG_CTRL, v); chk(v, 32'd1, "R7 status bit0 set");
    wr_reg(RG_CTRL, 32'h2);
    #1 chk({31'b0, local_irq}, 32'd0, "R7 irq masked");
    rd_reg(RG_CTRL, v); chk(v, 32'h3, "R7 status with mask");
    wr_reg(RG_CTRL, 32'h0);
    // R6 tail write with low bits and high bits discarded
    wr_reg(RG_TAIL, 32'h0001_000B);
    rd_reg(RG_TAIL, v); chk(v, 32'h8, "R6 tail masked");
    #1 chk({31'b0, local_irq}, 32'd0, "R7 irq clears when empty");
    rd_reg(RG_CTRL, v); chk(v, 32'd0, "R7 status clears when empty");

    // R5 retry during post window
    @(negedge clk);
    hst_acc_valid = 1; hst_acc_win0 = 1; hst_acc_write = 0; hst_acc_off = 8'h10;
    #1 chk({31'b0, hst_retry}, 32'd0, "R5 no retry when idle");
    @(negedge clk); hst_acc_valid = 0;
    host_acc(1, 1, 8'h40, 32'h0003_0000);
    hst_acc_valid = 1; hst_acc_write = 1; hst_acc_off = 8'h40; hst_acc_wdata = 32'hBAD0_BAD0;
    #1 chk({31'b0, hst_retry}, 32'd1, "R5 retry of port write in flight");
    @(negedge clk);
    hst_acc_write = 0; hst_acc_off = 8'h10;
    mem_ack = 1;
    #1 chk({31'b0, hst_retry}, 32'd1, "R5 retry in ack cycle");
    @(negedge clk);
    hst_acc_valid = 0; mem_ack = 0;
    head_m = (head_m + 4) % span_m;
    #1 chk({31'b0, mem_req}, 32'd0, "R5 retried post has no effect");
    @(negedge clk); #1 chk({31'b0, mem_req}, 32'd0, "R5 still no second write");
    rd_reg(RG_HEAD, v); chk(v, head_m, "R5 head advanced once");

    // R8 full ring drops post
    wr_reg(RG_TAIL, head_m + 4);
    host_acc(1, 1, 8'h40, 32'h0004_0000);
    #1 chk({31'b0, mem_req}, 32'd0, "R8 full post not written");
    rd_reg(RG_HEAD, v); chk(v, head_m, "R8 head unchanged when full");
    rd_reg(RG_CTRL, v); chk(v, 32'h5, "R8 overflow flag set");
    wr_reg(RG_CTRL, 32'h4);
    rd_reg(RG_CTRL, v); chk(v, 32'h1, "R8 overflow flag cleared");
    wr_reg(RG_TAIL, head_m);

    // R2 size codes, including saturation
    wr_reg(RG_SIZE, 32'd1); span_m = 32'h8000;
    host_acc(1, 1, 8'h40, 32'h0005_0000);
    finish_post(32'h0005_0000, 0);
    wr_reg(RG_SIZE, 32'd7); span_m = 32'h4_0000;
    host_acc(1, 1, 8'h40, 32'h0006_0000);
    finish_post(32'h0006_0000, 1);
    wr_reg(RG_SIZE, 32'd0); span_m = 32'h4000;

    // R4 wrap at the end of the ring
    wr_reg(RG_TAIL, head_m);
    while (head_m != span_m - 4) fast_post(head_m);
    host_acc(1, 1, 8'h40, 32'h0007_0000);
    finish_post(32'h0007_0000, 0);
    chk(head_m, 32'd0, "R4 model wrapped");
    rd_reg(RG_HEAD, v); chk(v, 32'd0, "R4 head wraps to zero");
    #1 chk({31'b0, local_irq}, 32'd1, "R7 irq after wrap nonempty");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule